// File: doc/BRIEF.md
# Common-Start Gate Generator

This block sits at the front of a time-coding readout channel. A synchronized, one-cycle common-start pulse opens an acquisition gate. The gate stays open for a time set by an 8-bit time-out value and then closes. Downstream hit-recording logic records hits only while the gate is high; anything that arrives while the gate is low is ignored.

The gate length is a fixed 50 ns pedestal plus 25 ns for each count of the time-out value. With a 40 MHz clock this is N + 2 cycles, which gives gates from 75 ns to just under 6.5 µs in 25 ns steps. A time-out of zero is not a legal setting, so the block treats it as one.

During the gate the block also watches two other inputs. A fast-clear pulse marks the event as cancelled, but it does not shorten the gate. A second start pulse marks the event as piled up, and it neither restarts nor lengthens the gate. When the gate closes, a one-cycle end-of-gate pulse carries both markers to the event builder, and the markers are then cleared.

Top module: `cs_gate_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, all outputs (gate, end-of-gate, cancelled, second-start) are low.
- R2: A start pulse sampled while the gate is closed raises the gate in the next cycle. The gate then stays high for exactly N + 2 consecutive cycles, where N is the time-out value in the range 1..255.
- R3: A time-out value of 0 gives the same gate as a value of 1, which is 3 cycles.
- R4: The time-out value is captured on the cycle the start is accepted. Changing it while the gate is open has no effect on the current gate length.
- R5: A start pulse sampled while the gate is open does not restart or lengthen the gate. It sets the second-start flag, and the flag stays high until the event ends.
- R6: A clear pulse sampled while the gate is open sets the cancelled flag, including on the last open cycle. The flag stays high until the event ends, and the gate still runs its full length.
- R7: A clear pulse sampled while the gate is closed is ignored: it opens no gate and sets no flag for the next event.
- R8: The end-of-gate pulse is high for exactly one cycle, which is the first cycle after the gate falls. In that cycle the cancelled and second-start flags show the event's outcome. Both flags are low in the following cycle.
- R9: A start pulse sampled in the end-of-gate cycle opens a new gate in the next cycle, and that new event's flags start low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 25 ns period assumed |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Synchronized common-start pulse, one cycle |
| clear_i | input | 1 | Synchronized fast-clear pulse, one cycle |
| timeout_i | input | TO_W | Gate time-out value N |
| gate_o | output | 1 | Acquisition gate; hits are recorded only while high |
| gate_end_o | output | 1 | One-cycle pulse in the cycle after the gate falls |
| cancelled_o | output | 1 | The current event received a clear |
| second_start_o | output | 1 | The current event saw a repeated start |

## Verification
The bench measures gate length exactly at the extremes of the range (0, 1 and 255) and at mid-range values.
- An off-by-one in the pedestal shows up as a gate that is one cycle too short or too long.
- A design that reads the time-out value live instead of capturing it lengthens the gate when the value changes mid-gate.
- A design that retriggers on a repeated start lengthens the gate past N + 2.

The clear pulse is tested in three places: in the middle of the gate, on the very last open cycle, and while the gate is closed.
- A design that truncates the gate on clear produces a short gate.
- A design that ignores a clear on the last cycle drops the flag.
- A design that latches an idle clear marks the next clean event as cancelled.

Finally, a start arriving exactly in the end-of-gate cycle must open a fresh gate with clear flags. A design that leaked the previous event's flags, or swallowed that start, would fail this test.

// File: rtl/cs_gate_pkg.sv
package cs_gate_pkg;
  // Fixed pedestal expressed in clock cycles (50 ns at 25 ns per cycle)
  localparam int PEDESTAL_CYCLES = 2;

  typedef enum logic {
    G_IDLE = 1'b0,
    G_OPEN = 1'b1
  } gate_state_e;
endpackage

// File: rtl/cs_gate_timer.sv
module cs_gate_timer
  import cs_gate_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [TO_W-1:0] timeout,
  output logic            gate,
  output logic            gate_end
);
  localparam int CW = TO_W + 1;

  gate_state_e     state;
  logic [CW-1:0]   remain;
  logic [TO_W-1:0] n_eff;
  logic [CW-1:0]   load_val;

  // A zero setting is illegal and is promoted to the shortest legal gate
  always_comb begin
    n_eff    = (timeout == '0) ? TO_W'(1) : timeout;
    load_val = {1'b0, n_eff} + CW'(PEDESTAL_CYCLES - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= G_IDLE;
      remain   <= '0;
      gate_end <= 1'b0;
    end else begin
      gate_end <= 1'b0;
      case (state)
        G_IDLE: begin
          if (start) begin
            state  <= G_OPEN;
            remain <= load_val;
          end
        end
        G_OPEN: begin
          if (remain == '0) begin
            state    <= G_IDLE;
            gate_end <= 1'b1;
          end else begin
            remain <= remain - CW'(1);
          end
        end
        default: state <= G_IDLE;
      endcase
    end
  end

  assign gate = (state == G_OPEN);
endmodule

// File: rtl/cs_gate_flag.sv
module cs_gate_flag (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic gate_end,
  input  logic event_in,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (gate && event_in) begin
      flag <= 1'b1;
    end else if (gate_end) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cs_gate_gen.sv
module cs_gate_gen #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            clear_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            gate_o,
  output logic            gate_end_o,
  output logic            cancelled_o,
  output logic            second_start_o
);
  localparam int NFLAG = 2;

  logic             gate_w;
  logic             end_w;
  logic [NFLAG-1:0] ev_in;
  logic [NFLAG-1:0] flags;

  cs_gate_timer #(.TO_W(TO_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start_i),
    .timeout  (timeout_i),
    .gate     (gate_w),
    .gate_end (end_w)
  );

  // index 0: cancelled by clear, index 1: repeated start
  assign ev_in = {start_i, clear_i};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    cs_gate_flag flag_i (
      .clk      (clk),
      .rst      (rst),
      .gate     (gate_w),
      .gate_end (end_w),
      .event_in (ev_in[i]),
      .flag     (flags[i])
    );
  end

  assign gate_o         = gate_w;
  assign gate_end_o     = end_w;
  assign cancelled_o    = flags[0];
  assign second_start_o = flags[1];
endmodule

// File: rtl/cs_gate_gen_chk.sv
module cs_gate_gen_chk #(
  parameter int TO_W = 8
) (
  input logic clk,
  input logic rst,
  input logic gate_o,
  input logic gate_end_o,
  input logic cancelled_o,
  input logic second_start_o
);
  localparam int MAX_LEN = (1 << TO_W) + 1;
  localparam int LW      = TO_W + 2;

  logic [LW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || !gate_o) run_len <= '0;
    else                run_len <= run_len + LW'(1);
  end

  // R2
  gate_min_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |=> gate_o ##1 gate_o);

  // R2
  gate_max_len_chk: assert property (@(posedge clk) disable iff (rst)
    run_len <= LW'(MAX_LEN));

  // R8
  end_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    gate_end_o |-> (!gate_o && $past(gate_o)));

  // R8
  end_single_chk: assert property (@(posedge clk) disable iff (rst)
    gate_end_o |=> !gate_end_o);

  // R6
  cancel_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cancelled_o) && $past(gate_o)) |-> cancelled_o);

  // R5
  pile_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(second_start_o) && $past(gate_o)) |-> second_start_o);

  // R8
  flags_in_event_chk: assert property (@(posedge clk) disable iff (rst)
    (cancelled_o || second_start_o) |-> (gate_o || gate_end_o));
endmodule

bind cs_gate_gen cs_gate_gen_chk #(.TO_W(TO_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .gate_o         (gate_o),
  .gate_end_o     (gate_end_o),
  .cancelled_o    (cancelled_o),
  .second_start_o (second_start_o)
);

// File: tb/cs_gate_gen_test.sv
module cs_gate_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       clear_i = 1'b0;
  logic [7:0] timeout_i = 8'd1;
  logic       gate_o, gate_end_o, cancelled_o, second_start_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  cs_gate_gen #(.TO_W(8)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .clear_i(clear_i),
    .timeout_i(timeout_i), .gate_o(gate_o), .gate_end_o(gate_end_o),
    .cancelled_o(cancelled_o), .second_start_o(second_start_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one event; action indices count open-gate cycles from 0, -1 = none
  task automatic run_event(input int n, input int clr_at, input int st_at,
                           input int chg_at, input int chg_val,
                           input bit exp_c, input bit exp_p, input string req);
    int len = 0;
    int exp_len = ((n == 0) ? 1 : n) + 2;
    timeout_i = 8'(n);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (gate_o === 1'b1 && len < 600) begin
      clear_i = (len == clr_at);
      start_i = (len == st_at);
      if (len == chg_at) timeout_i = 8'(chg_val);
      len++;
      @(negedge clk);
      clear_i = 1'b0;
      start_i = 1'b0;
    end
    check(len == exp_len, {req, " gate length"}, len, exp_len);
    check(gate_end_o === 1'b1, "R8 end pulse after fall", int'(gate_end_o), 1);
    check(cancelled_o === exp_c, {req, " cancelled at end"}, int'(cancelled_o), int'(exp_c));
    check(second_start_o === exp_p, {req, " second start at end"}, int'(second_start_o), int'(exp_p));
    @(negedge clk);
    check(gate_end_o === 1'b0, "R8 end pulse single cycle", int'(gate_end_o), 0);
    check(cancelled_o === 1'b0 && second_start_o === 1'b0, "R8 flags cleared",
          int'({cancelled_o, second_start_o}), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic test_reset;
    check(!gate_o && !gate_end_o && !cancelled_o && !second_start_o, "R1 reset outputs",
          int'({gate_o, gate_end_o, cancelled_o, second_start_o}), 0);
  endtask

  task automatic test_lengths;
    run_event(1,   -1, -1, -1, 0, 1'b0, 1'b0, "R2 n=1");
    run_event(5,   -1, -1, -1, 0, 1'b0, 1'b0, "R2 n=5");
    run_event(255, -1, -1, -1, 0, 1'b0, 1'b0, "R2 n=255");
    run_event(0,   -1, -1, -1, 0, 1'b0, 1'b0, "R3 n=0");
  endtask

  task automatic test_capture;
    run_event(4, -1, -1, 1, 20, 1'b0, 1'b0, "R4 timeout change mid-gate");
  endtask

  task automatic test_pileup;
    run_event(6, -1, 2, -1, 0, 1'b0, 1'b1, "R5 repeated start");
  endtask

  task automatic test_clear;
    run_event(6, 3, -1, -1, 0, 1'b1, 1'b0, "R6 clear mid-gate");
    run_event(6, 7, -1, -1, 0, 1'b1, 1'b0, "R6 clear last cycle");
  endtask

  task automatic test_idle_clear;
    @(negedge clk) clear_i = 1'b1;
    @(negedge clk) clear_i = 1'b0;
    check(gate_o === 1'b0 && cancelled_o === 1'b0, "R7 idle clear ignored",
          int'({gate_o, cancelled_o}), 0);
    run_event(3, -1, -1, -1, 0, 1'b0, 1'b0, "R7 event after idle clear");
  endtask

  task automatic test_back_to_back;
    int len = 0;
    timeout_i = 8'd2;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    clear_i = 1'b1;
    @(negedge clk) clear_i = 1'b0;
    while (gate_o === 1'b1 && len < 600) begin
      len++;
      @(negedge clk);
    end
    check(gate_end_o === 1'b1 && cancelled_o === 1'b1, "R9 first event ends cancelled",
          int'({gate_end_o, cancelled_o}), 3);
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(gate_o === 1'b1, "R9 new gate opens", int'(gate_o), 1);
    check(cancelled_o === 1'b0 && second_start_o === 1'b0, "R9 new event flags clean",
          int'({cancelled_o, second_start_o}), 0);
    len = 0;
    while (gate_o === 1'b1 && len < 600) begin
      len++;
      @(negedge clk);
    end
    check(len == 4, "R9 new gate length", len, 4);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_lengths();
    test_capture();
    test_pileup();
    test_clear();
    test_idle_clear();
    test_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule